// File: doc/BRIEF.md
# Passing Delay Window Finder

This block picks a sampling delay from a tap sweep. Another part of the chip steps an input delay line through 32 taps and records, for each tap, whether sampling at that setting was error-free. The result is a 32-bit map in which bit i is 1 when tap i passed. A one-cycle start strobe hands the map to the block. The block then searches for the longest unbroken group of passing taps and reports three values: the tap where that group begins, how many taps it covers, and a recommended tap inside it.

The search takes one run per clock. A run is a stretch of consecutive ones, or a single failing tap. Each step jumps the scan position to the end of the current run, so sparse or fragmented maps settle quickly. The search can stop early. Once a run of at least eight taps is in hand and the best window found so far starts near the low end of the delay line, there is no point in scanning further, so the block stops. The recommended tap sits one third of the way into the window when the window starts at tap 0. Otherwise it sits halfway in. A map with no passing tap gives a sentinel tap value and raises an error flag.

When the result is ready, a one-cycle done pulse is raised. The result outputs then keep their values until the next search finishes.

Top module: `tap_window_finder`

## Requirements
- R1: After reset, `done` is 0 and `winStart`, `winLen`, `winPhase` and `winErr` are all 0.
- R2: Bit i of `passMap` is tap i. Runs are counted upward and end at tap 31 without wrapping to tap 0, so a map with only bits 31 and 0 set gives a window of length 1 at tap 0.
- R3: A run replaces the best window only when it is strictly longer. Among equally long runs, the lowest-numbered one is reported.
- R4: The search stops as soon as a run of 8 or more taps has been evaluated and the best window at that point starts below tap 4. Longer runs at higher taps are then not considered. A best window starting at tap 4 or above does not stop the search.
- R5: When the window starts at tap 0, `winPhase` is (start + length/3) mod 32. Otherwise it is (start + length/2) mod 32. Both divisions are integer divisions.
- R6: A map with no bit set reports `winErr`=1, `winPhase`=0xFF, `winStart`=0 and `winLen`=0. Any other map reports `winErr`=0.
- R7: `done` is high for exactly one cycle per accepted start. The result outputs change only in the cycle in which `done` rises, and they keep their values until the next search finishes.
- R8: A `start` that arrives while a search is running is ignored. Its map does not affect the result in progress, and it causes no extra `done` pulse.
- R9: A single passing tap at tap 31 is reported as start 31, length 1, phase 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle strobe that begins a search with the current `passMap` |
| passMap | input | 32 | Pass/fail map; bit i is 1 when tap i passed |
| done | output | 1 | One-cycle pulse when a result is ready |
| winStart | output | 8 | First tap of the longest passing run |
| winLen | output | 8 | Number of taps in that run |
| winPhase | output | 8 | Recommended tap, or 0xFF when no tap passed |
| winErr | output | 1 | High when the map has no passing tap |

## Verification
The assertions assume the following about the inputs:
- `passMap` is sampled only in the cycle in which `start` is accepted.
- `start` may arrive at any time, including in the middle of a search.
- Reset is held for at least one clock edge before the first start.

The bench meets these assumptions as follows:
- It drives inputs on the falling edge.
- It holds `start` for a single cycle.
- It waits for each result before issuing the next search, except in one deliberate case. In that case a second strobe, carrying a different map, lands in the middle of a long scan of an alternating map.

The expected results come from a separate loop model of the search written from the requirements.

// File: rtl/winfind_pkg.sv
package winfind_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_FINISH
  } finder_state_t;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } finder_strobe_t;

endpackage

// File: rtl/winfind_runlen.sv
module winfind_runlen #(
  parameter int TAPS  = 32,
  parameter int LEN_W = 6
) (
  input  logic [TAPS-1:0]  tapBits,
  output logic [LEN_W-1:0] runLen
);

  logic [TAPS-1:0] prefixPass;

  assign prefixPass[0] = tapBits[0];

  genvar gi;
  generate
    for (gi = 1; gi < TAPS; gi++) begin : g_prefix
      assign prefixPass[gi] = prefixPass[gi-1] & tapBits[gi];
    end
  endgenerate

  assign runLen = LEN_W'($countones(prefixPass));

endmodule

// File: rtl/winfind_ctrl.sv
module winfind_ctrl
  import winfind_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic           scanDone,
  output finder_strobe_t strobes,
  output logic           done
);

  finder_state_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (start) stateNext = ST_SCAN;
      ST_SCAN:   if (scanDone) stateNext = ST_FINISH;
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobes.load   = (state == ST_IDLE) && start;
    strobes.step   = (state == ST_SCAN);
    strobes.finish = (state == ST_FINISH);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobes.finish;
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_no_reload_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> !strobes.load);

endmodule

// File: rtl/winfind_datapath.sv
module winfind_datapath
  import winfind_pkg::*;
#(
  parameter int TAPS        = 32,
  parameter int OUT_W       = 8,
  parameter int EARLY_LEN   = 8,
  parameter int EARLY_START = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  finder_strobe_t   strobes,
  input  logic [TAPS-1:0]  mapIn,
  output logic             scanDone,
  output logic [OUT_W-1:0] outStart,
  output logic [OUT_W-1:0] outLen,
  output logic [OUT_W-1:0] outPhase,
  output logic             outErr
);

  localparam int POS_W = $clog2(TAPS + 1);
  localparam logic [POS_W-1:0] TAPS_P   = POS_W'(TAPS);
  localparam logic [POS_W-1:0] ELEN_P   = POS_W'(EARLY_LEN);
  localparam logic [POS_W-1:0] ESTART_P = POS_W'(EARLY_START);
  localparam logic [POS_W-1:0] ONE_P    = POS_W'(1);
  localparam logic [POS_W-1:0] THREE_P  = POS_W'(3);
  localparam logic [POS_W-1:0] TWO_P    = POS_W'(2);

  logic [TAPS-1:0]  mapReg;
  logic [POS_W-1:0] pos, bestStart, bestLen;
  logic [POS_W-1:0] curLen, advance, nextPos;
  logic [POS_W-1:0] candStart, candLen;
  logic [POS_W-1:0] offset, phaseRaw;
  logic             takeRun, earlyStop;

  winfind_runlen #(.TAPS(TAPS), .LEN_W(POS_W)) u_runlen (
    .tapBits (mapReg >> pos),
    .runLen  (curLen)
  );

  always_comb begin
    takeRun   = curLen > bestLen;
    candStart = takeRun ? pos : bestStart;
    candLen   = takeRun ? curLen : bestLen;
    advance   = (curLen == '0) ? ONE_P : curLen;
    nextPos   = pos + advance;
    earlyStop = (curLen >= ELEN_P) && (candStart < ESTART_P);
    scanDone  = strobes.step && ((nextPos >= TAPS_P) || earlyStop);
  end

  always_comb begin
    offset   = (bestStart == '0) ? (bestLen / THREE_P) : (bestLen / TWO_P);
    phaseRaw = POS_W'((bestStart + offset) % TAPS_P);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mapReg    <= '0;
      pos       <= '0;
      bestStart <= '0;
      bestLen   <= '0;
    end else if (strobes.load) begin
      mapReg    <= mapIn;
      pos       <= '0;
      bestStart <= '0;
      bestLen   <= '0;
    end else if (strobes.step) begin
      pos       <= nextPos;
      bestStart <= candStart;
      bestLen   <= candLen;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outStart <= '0;
      outLen   <= '0;
      outPhase <= '0;
      outErr   <= 1'b0;
    end else if (strobes.finish) begin
      if (bestLen == '0) begin
        outStart <= '0;
        outLen   <= '0;
        outPhase <= '1;
        outErr   <= 1'b1;
      end else begin
        outStart <= OUT_W'(bestStart);
        outLen   <= OUT_W'(bestLen);
        outPhase <= OUT_W'(phaseRaw);
        outErr   <= 1'b0;
      end
    end
  end

  assert_pos_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    pos <= TAPS_P);

  assert_best_grows_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> bestLen >= $past(bestLen));

  assert_early_halt_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && earlyStop) |=> !strobes.step);

  assert_phase_inside_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outLen != '0) |-> ((outPhase >= outStart) &&
      ({1'b0, outPhase} < ({1'b0, outStart} + {1'b0, outLen}))));

  assert_err_sentinel_R6: assert property (@(posedge clk) disable iff (!rstN)
    outErr |-> ((outPhase == '1) && (outLen == '0)));

  assert_map_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(mapReg));

endmodule

// File: rtl/tap_window_finder.sv
module tap_window_finder
  import winfind_pkg::*;
#(
  parameter int TAPS        = 32,
  parameter int OUT_W       = 8,
  parameter int EARLY_LEN   = 8,
  parameter int EARLY_START = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [TAPS-1:0]  passMap,
  output logic             done,
  output logic [OUT_W-1:0] winStart,
  output logic [OUT_W-1:0] winLen,
  output logic [OUT_W-1:0] winPhase,
  output logic             winErr
);

  finder_strobe_t strobes;
  logic           scanDone;

  winfind_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .scanDone (scanDone),
    .strobes  (strobes),
    .done     (done)
  );

  winfind_datapath #(
    .TAPS        (TAPS),
    .OUT_W       (OUT_W),
    .EARLY_LEN   (EARLY_LEN),
    .EARLY_START (EARLY_START)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .mapIn    (passMap),
    .scanDone (scanDone),
    .outStart (winStart),
    .outLen   (winLen),
    .outPhase (winPhase),
    .outErr   (winErr)
  );

endmodule

// File: tb/tb_tap_window_finder.sv
module tb_tap_window_finder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] passMap = '0;
  logic        done;
  logic [7:0]  winStart, winLen, winPhase;
  logic        winErr;

  int errors = 0;
  int checks = 0;
  int resultsSeen = 0;
  int issued = 0;
  bit finished = 0;
  bit prevDone = 0;

  typedef struct {
    int    eStart;
    int    eLen;
    int    ePhase;
    int    eErr;
    string tag;
  } exp_t;

  exp_t expQ[$];
  exp_t lastExp;

  always #10 clk = ~clk;

  tap_window_finder dut (
    .clk(clk), .rstN(rstN), .start(start), .passMap(passMap),
    .done(done), .winStart(winStart), .winLen(winLen),
    .winPhase(winPhase), .winErr(winErr)
  );

  function automatic exp_t model(logic [31:0] m, string tag);
    exp_t e;
    int s = 0, l, bs = 0, bl = 0;
    while (s < 32) begin
      l = 0;
      while ((s + l) < 32 && m[s + l]) l++;
      if (l > bl) begin bs = s; bl = l; end
      s += (l != 0) ? l : 1;
      if (l >= 8 && bs < 4) break;
    end
    e.tag = tag;
    if (bl == 0) begin
      e.eStart = 0; e.eLen = 0; e.ePhase = 255; e.eErr = 1;
    end else begin
      e.eStart = bs; e.eLen = bl; e.eErr = 0;
      e.ePhase = (bs == 0) ? ((bs + bl / 3) % 32) : ((bs + bl / 2) % 32);
    end
    return e;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic waitResult();
    while (resultsSeen < issued) @(negedge clk);
  endtask

  task automatic runSearch(logic [31:0] m, string tag);
    @(negedge clk);
    passMap = m;
    start = 1'b1;
    expQ.push_back(model(m, tag));
    issued++;
    @(negedge clk);
    start = 1'b0;
    waitResult();
  endtask

  task automatic runWithBusyStart(logic [31:0] m, logic [31:0] other, string tag);
    @(negedge clk);
    passMap = m;
    start = 1'b1;
    expQ.push_back(model(m, tag));
    issued++;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    passMap = other;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitResult();
    repeat (40) @(negedge clk);
    check(resultsSeen == issued, "R8", "extra done pulses", resultsSeen, issued);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (prevDone) check(!done, "R7", "done width", int'(done), 0);
      if (done) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R7", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          lastExp = e;
          check(int'(winStart) == e.eStart, e.tag, "winStart", int'(winStart), e.eStart);
          check(int'(winLen) == e.eLen, e.tag, "winLen", int'(winLen), e.eLen);
          check(int'(winPhase) == e.ePhase, e.tag, "winPhase", int'(winPhase), e.ePhase);
          check(int'(winErr) == e.eErr, e.tag, "winErr", int'(winErr), e.eErr);
        end
        resultsSeen++;
      end
      prevDone = done;
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1", "done", int'(done), 0);
    check(winStart == 8'd0 && winLen == 8'd0, "R1", "start/len", int'(winStart) + int'(winLen), 0);
    check(winPhase == 8'd0, "R1", "phase", int'(winPhase), 0);
    check(winErr == 1'b0, "R1", "err", int'(winErr), 0);

    runSearch(32'h00F0_0F00, "R3");          // two equal runs, earliest wins
    runSearch(32'hF0F0_F0F0, "R3");
    runSearch(32'h0000_0000, "R6");          // all fail
    runSearch(32'hFFFF_FFFF, "R5");          // start 0: length/3
    runSearch(32'h0000_001F, "R5");
    runSearch(32'h0000_0006, "R5");          // nonzero start: length/2
    runSearch(32'h03FF_C0FF, "R4");          // early stop at tap 0 run
    runSearch(32'h3FFF_CFF0, "R4");          // best at tap 4: no early stop
    runSearch(32'h7FFF_E7F8, "R4");          // best at tap 3: early stop
    runSearch(32'h8000_0001, "R2");          // no wrap
    runSearch(32'h8000_0000, "R9");

    // R7: outputs held after done
    repeat (5) @(negedge clk);
    check(int'(winStart) == lastExp.eStart && int'(winLen) == lastExp.eLen,
          "R7", "held start+len", int'(winStart) + int'(winLen), lastExp.eStart + lastExp.eLen);
    check(int'(winPhase) == lastExp.ePhase, "R7", "held phase", int'(winPhase), lastExp.ePhase);

    runWithBusyStart(32'h5555_5555, 32'hFFFF_FFFF, "R8");
    runSearch(32'h0000_0000, "R6");
    runSearch(32'h00FF_0000, "R5");

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule